// File: doc/BRIEF.md
# Split Strobe Sequencer with Runaway Guard

This block drives the strobe enables of a line thermal head whose dots are divided into groups. Only one group draws current at any time. One strobe-on pulse from the CPU starts an automatic run over two or three groups. Each group is energized for a programmed number of clock cycles, and every pair of groups is separated by one idle cycle. No CPU action is needed between groups.

A hardware watchdog bounds how long any strobe can remain active, so a stuck sequence or a wrong on-time value cannot overheat the head. When the watchdog trips, it turns every strobe off and drops the head supply enable. It also raises a fault flag that stays set until the CPU clears it. A pin selects whether the strobe outputs are active high or active low, so the block can drive either kind of head driver without external inverters.

Top module: `strb_ctl`

## Requirements
- R1: While reset is asserted, all strobes are inactive, `busy_o` is 0, `fault_o` is 0 and `head_pwr_o` is 1.
- R2: A 1 on `fire_i` at a rising edge while idle and not faulted makes group 0 active from the next cycle for ON cycles. Each later group follows after exactly one cycle with all strobes inactive. Group g drives `strb_o[g]`, and at most one group is active in any cycle.
- R3: If `three_grp_i` is 1 at start, the run covers groups 0, 1 and 2. If it is 0, the run covers groups 0 and 1, and `strb_o[2]` stays inactive. The mode is captured at start, and later changes have no effect on the run.
- R4: At most one strobe is active in any cycle.
- R5: With `act_low_i` = 1, every `strb_o` bit is the inverse of its active state (inactive = 1). With 0, active = 1. The pin acts in the same cycle.
- R6: An `on_time_i` of 0 is treated as 1 cycle per group.
- R7: A `fire_i` pulse during a run is ignored, and the run continues unchanged.
- R8: If a strobe stays continuously active for more than MAX = `max_time_i` cycles, it is active for exactly MAX+1 cycles. In the next cycle, all strobes are inactive, `busy_o` is 0, `fault_o` is 1 and `head_pwr_o` is 0. A run whose per-group length equals MAX does not trip.
- R9: `fault_o` stays set until `fault_clr_i` is 1 at a rising edge. While it is set, `fire_i` is ignored. After the clearing edge, `fault_o` is 0 and `head_pwr_o` is 1.
- R10: `busy_o` is 1 from the cycle after the starting edge through the last active cycle of the last group, and 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fire_i | input | 1 | Strobe-on request; starts a run at a rising edge |
| three_grp_i | input | 1 | 1 = three groups, 0 = two groups; captured at start |
| act_low_i | input | 1 | 1 = strobe outputs active low |
| on_time_i | input | TW | Per-group on-time in clock cycles (0 treated as 1) |
| max_time_i | input | TW | Maximum continuous strobe on-time before the guard trips |
| fault_clr_i | input | 1 | Clears the sticky fault flag |
| strb_o | output | GN | Group strobe outputs |
| head_pwr_o | output | 1 | Head supply enable; 0 while faulted |
| busy_o | output | 1 | A run is in progress |
| fault_o | output | 1 | Sticky watchdog fault flag |

## Verification
Group 0 appears one cycle after the starting edge. Group g begins g×(ON+1) cycles after that, and `busy_o` falls (last+1)×(ON+1) cycles after the start. The watchdog removes the strobe and raises `fault_o` MAX+1 cycles after the strobe rose. A fault clear takes effect one cycle after its edge, and the polarity pin takes effect in the same cycle. The bench drives inputs and samples outputs on the falling edge. It compares every cycle of each run against a cycle-indexed model built from these counts, so an early or late transition by one cycle is reported at the cycle where it occurs.

// File: rtl/strb_pkg.sv
package strb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_GAP  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/strb_seq.sv
module strb_seq
  import strb_pkg::*;
#(
  parameter int TW = 16,
  parameter int GN = 3,
  localparam int GW = (GN > 1) ? $clog2(GN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          three_grp_i,
  input  logic [TW-1:0] on_time_i,
  input  logic          kill_i,
  input  logic          block_i,
  output logic [GN-1:0] act_o,
  output logic [GW-1:0] last_o,
  output logic          busy_o
);
  localparam logic [GW-1:0] GRP_ALL  = GW'(GN - 1);
  localparam logic [GW-1:0] GRP_LESS = GW'(GN - 2);

  seq_st_e       st_q;
  logic [GW-1:0] grp_q;
  logic [GW-1:0] last_q;
  logic [TW-1:0] tmr_q;
  logic [TW-1:0] on_m1;

  // zero on-time behaves as a single cycle
  assign on_m1 = (on_time_i == '0) ? '0 : on_time_i - TW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      grp_q  <= '0;
      last_q <= GRP_ALL;
      tmr_q  <= '0;
    end else if (kill_i) begin
      st_q <= ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (fire_i && !block_i) begin
            st_q   <= ST_ON;
            grp_q  <= '0;
            tmr_q  <= on_m1;
            last_q <= three_grp_i ? GRP_ALL : GRP_LESS;
          end
        end
        ST_ON: begin
          if (tmr_q == '0) begin
            st_q <= (grp_q == last_q) ? ST_IDLE : ST_GAP;
          end else begin
            tmr_q <= tmr_q - TW'(1);
          end
        end
        ST_GAP: begin
          st_q  <= ST_ON;
          grp_q <= grp_q + GW'(1);
          tmr_q <= on_m1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < GN; g++) begin : g_act
    assign act_o[g] = (st_q == ST_ON) && (grp_q == GW'(g));
  end

  assign busy_o = (st_q != ST_IDLE);
  assign last_o = last_q;
endmodule

// File: rtl/strb_guard.sv
module strb_guard #(
  parameter int TW = 16,
  parameter int GN = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [GN-1:0] act_i,
  input  logic [TW-1:0] max_time_i,
  input  logic          fault_clr_i,
  output logic          trip_o,
  output logic          fault_o
);
  logic [TW-1:0] wd_q;
  logic          fault_q;
  logic          on_any;

  assign on_any = |act_i;
  // wd_q holds the number of earlier cycles in the current active run
  assign trip_o = on_any && (wd_q >= max_time_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wd_q <= '0;
    end else if (!on_any) begin
      wd_q <= '0;
    end else if (wd_q != '1) begin
      wd_q <= wd_q + TW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
    end else if (trip_o) begin
      fault_q <= 1'b1;
    end else if (fault_clr_i) begin
      fault_q <= 1'b0;
    end
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/strb_drv.sv
module strb_drv #(
  parameter int GN = 3
) (
  input  logic [GN-1:0] act_i,
  input  logic          act_low_i,
  input  logic          fault_i,
  output logic [GN-1:0] strb_o,
  output logic          head_pwr_o
);
  for (genvar g = 0; g < GN; g++) begin : g_pin
    // fault gate is a second barrier behind the sequencer kill
    assign strb_o[g] = (act_i[g] && !fault_i) ^ act_low_i;
  end

  assign head_pwr_o = !fault_i;
endmodule

// File: rtl/strb_ctl.sv
module strb_ctl #(
  parameter int TW = 16,
  parameter int GN = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          three_grp_i,
  input  logic          act_low_i,
  input  logic [TW-1:0] on_time_i,
  input  logic [TW-1:0] max_time_i,
  input  logic          fault_clr_i,
  output logic [GN-1:0] strb_o,
  output logic          head_pwr_o,
  output logic          busy_o,
  output logic          fault_o
);
  localparam int GW = (GN > 1) ? $clog2(GN) : 1;

  logic [GN-1:0] act_w;
  logic [GW-1:0] last_w;
  logic          trip_w;
  logic          fault_w;

  strb_seq #(.TW(TW), .GN(GN)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire_i),
    .three_grp_i (three_grp_i),
    .on_time_i   (on_time_i),
    .kill_i      (trip_w),
    .block_i     (fault_w),
    .act_o       (act_w),
    .last_o      (last_w),
    .busy_o      (busy_o)
  );

  strb_guard #(.TW(TW), .GN(GN)) u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .act_i       (act_w),
    .max_time_i  (max_time_i),
    .fault_clr_i (fault_clr_i),
    .trip_o      (trip_w),
    .fault_o     (fault_w)
  );

  strb_drv #(.GN(GN)) u_drv (
    .act_i      (act_w),
    .act_low_i  (act_low_i),
    .fault_i    (fault_w),
    .strb_o     (strb_o),
    .head_pwr_o (head_pwr_o)
  );

  assign fault_o = fault_w;
endmodule

// File: rtl/strb_chk.sv
module strb_chk #(
  parameter int GN = 3,
  parameter int GW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fire_i,
  input logic          act_low_i,
  input logic          fault_clr_i,
  input logic [GN-1:0] strb_o,
  input logic          busy_o,
  input logic          fault_o,
  input logic [GW-1:0] last_i
);
  logic [GN-1:0] act;
  assign act = strb_o ^ {GN{act_low_i}};

  // R4
  one_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act));

  // R2
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act != '0) |=> (act == '0) || (act == $past(act)));

  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(fire_i));

  // R3
  two_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && last_i == GW'(GN - 2)) |-> !act[GN-1]);

  // R8
  fault_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (act == '0) && !busy_o);

  // R8
  trip_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(act != '0));

  // R9
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && !fault_clr_i) |=> fault_o);

  // R10
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act != '0) |-> busy_o);
endmodule

bind strb_ctl strb_chk #(.GN(GN), .GW(GW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fire_i      (fire_i),
  .act_low_i   (act_low_i),
  .fault_clr_i (fault_clr_i),
  .strb_o      (strb_o),
  .busy_o      (busy_o),
  .fault_o     (fault_o),
  .last_i      (last_w)
);

// File: tb/sim_strb_ctl.sv
`timescale 1ns/1ps
module sim_strb_ctl;
  localparam int TW = 16;
  localparam int GN = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fire = 1'b0;
  logic          three = 1'b1;
  logic          low = 1'b0;
  logic          clr = 1'b0;
  logic [TW-1:0] on_t = 16'd3;
  logic [TW-1:0] max_t = 16'd100;
  logic [GN-1:0] strb;
  logic          hpwr, busy, fault;
  int            n_chk = 0;
  int            n_fail = 0;

  always #2.5 clk = ~clk;

  strb_ctl #(.TW(TW), .GN(GN)) u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fire_i      (fire),
    .three_grp_i (three),
    .act_low_i   (low),
    .on_time_i   (on_t),
    .max_time_i  (max_t),
    .fault_clr_i (clr),
    .strb_o      (strb),
    .head_pwr_o  (hpwr),
    .busy_o      (busy),
    .fault_o     (fault)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [GN-1:0] exp_act(input int k, input int on, input int last);
    int per;
    int g;
    int pos;
    per = on + 1;
    g   = (k - 1) / per;
    pos = (k - 1) % per;
    if (g <= last && pos < on) return GN'(1) << g;
    return '0;
  endfunction

  task automatic run_seq(input int on_val, input bit three_m, input bit low_m,
                         input bit poke, input string req);
    int on_eff;
    int last;
    int total;
    on_eff = (on_val == 0) ? 1 : on_val;
    last   = three_m ? 2 : 1;
    total  = (last + 1) * (on_eff + 1) - 1;
    on_t  = TW'(on_val);
    three = three_m;
    low   = low_m;
    fire  = 1'b1;
    step;
    fire = 1'b0;
    for (int k = 1; k <= total; k++) begin
      check({req, " strobe"}, 32'(strb), 32'(exp_act(k, on_eff, last) ^ {GN{low_m}}));
      check({req, " R10 busy"}, 32'(busy), 32'd1);
      if (poke && k == 2) begin
        fire  = 1'b1;
        three = !three_m;
      end else begin
        fire = 1'b0;
      end
      step;
    end
    check({req, " idle strobe"}, 32'(strb), 32'({GN{low_m}}));
    check({req, " R10 busy end"}, 32'(busy), 32'd0);
    check({req, " no fault"}, 32'(fault), 32'd0);
    three = three_m;
    step;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #1;
    check("R1 strobe", 32'(strb), 32'd0);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 fault", 32'(fault), 32'd0);
    check("R1 head_pwr", 32'(hpwr), 32'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step;
  endtask

  task automatic t_basic;
    run_seq(3, 1'b1, 1'b0, 1'b0, "R2 three-group");
    run_seq(5, 1'b0, 1'b0, 1'b0, "R3 two-group");
    run_seq(2, 1'b1, 1'b0, 1'b0, "R3 three-group");
  endtask

  task automatic t_polarity;
    low = 1'b1;
    #1;
    check("R5 idle active-low", 32'(strb), 32'h7);
    low = 1'b0;
    #1;
    check("R5 idle active-high", 32'(strb), 32'h0);
    @(negedge clk);
    run_seq(4, 1'b1, 1'b1, 1'b0, "R5 active-low run");
    run_seq(2, 1'b0, 1'b1, 1'b0, "R5 active-low two-group");
    low = 1'b0;
  endtask

  task automatic t_zero_on;
    run_seq(0, 1'b1, 1'b0, 1'b0, "R6 zero on-time");
  endtask

  task automatic t_refire;
    run_seq(3, 1'b1, 1'b0, 1'b1, "R7 fire during run");
    run_seq(3, 1'b0, 1'b0, 1'b1, "R7 R3 mode change during run");
  endtask

  task automatic t_watchdog;
    max_t = 16'd3;
    run_seq(3, 1'b1, 1'b0, 1'b0, "R8 no trip at limit");
    max_t = 16'd4;
    on_t  = 16'd10;
    three = 1'b1;
    fire  = 1'b1;
    step;
    fire = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      check("R8 strobe before trip", 32'(strb), 32'h1);
      check("R8 no fault before trip", 32'(fault), 32'd0);
      step;
    end
    check("R8 strobe forced off", 32'(strb), 32'h0);
    check("R8 fault set", 32'(fault), 32'd1);
    check("R8 head_pwr dropped", 32'(hpwr), 32'd0);
    check("R8 busy cleared", 32'(busy), 32'd0);
    fire = 1'b1;
    step;
    fire = 1'b0;
    for (int k = 0; k < 3; k++) begin
      check("R9 fire ignored strobe", 32'(strb), 32'h0);
      check("R9 fire ignored busy", 32'(busy), 32'd0);
      check("R9 fault held", 32'(fault), 32'd1);
      step;
    end
    clr = 1'b1;
    step;
    clr = 1'b0;
    check("R9 fault cleared", 32'(fault), 32'd0);
    check("R9 head_pwr restored", 32'(hpwr), 32'd1);
    max_t = 16'd0;
    on_t  = 16'd3;
    fire  = 1'b1;
    step;
    fire = 1'b0;
    check("R8 max zero one cycle", 32'(strb), 32'h1);
    step;
    check("R8 max zero off", 32'(strb), 32'h0);
    check("R8 max zero fault", 32'(fault), 32'd1);
    clr = 1'b1;
    step;
    clr = 1'b0;
    check("R9 cleared again", 32'(fault), 32'd0);
    max_t = 16'd100;
    run_seq(2, 1'b1, 1'b0, 1'b0, "R9 run after clear");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_basic;
    t_polarity;
    t_zero_on;
    t_refire;
    t_watchdog;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule